// File: doc/BRIEF.md
# Conversion Result Capture and Serial Readout Port

This block sits behind a successive-approximation converter core and turns its bit-by-bit decisions into a word that a host reads serially. While a conversion runs, each decision strobe writes one comparator result into a working register at the bit position it names. When the conversion finishes, the whole working word is copied in parallel into a separate output shift register. From there it is shifted out MSB first on a serial data line. The output word is in binary two's complement, so the codes pass through unchanged.

The serial clock comes from one of two sources. In internal mode the block generates a fixed burst of data clock pulses after every load. In external mode the host supplies the data clock itself. External mode has one hazard. If the host is clocking with its select asserted at the moment the load would occur, the load is skipped and the new result is dropped. A sticky flag reports this, and it clears when the next conversion starts.

Top module: `sar_result_port`

## Requirements
- R1: A decision strobe writes `bit_val` into working-register bit `bit_idx` (index WIDTH-1 is the MSB) and leaves every other bit alone; writing the same index again overwrites only that bit.
- R2: The output shift register loads the whole working word on the clock edge where `conv_busy` is first sampled low after being high, and at no other edge.
- R3: While `conv_busy` stays high, the output shift register keeps the previous result, so a host read during a conversion returns the earlier word.
- R4: When `ext_clk_sel`=1, `ext_dclk`=1 and `host_sel_n`=0 at the load edge, the load is skipped, the shift register keeps its old content and `result_lost` becomes 1.
- R5: In external mode, if `ext_dclk` is 0 or `host_sel_n` is 1 at the load edge, the load takes place and `result_lost` stays 0.
- R6: `result_lost` stays set until the edge where `conv_busy` is first sampled high, which clears it.
- R7: In internal mode (`ext_clk_sel`=0), each load starts a burst of exactly WIDTH pulses on `dclk_out`. Each pulse is HALF_DIV clocks high and HALF_DIV clocks low, and the first one rises HALF_DIV clocks after the load edge. After the burst `dclk_out` stays low, and it is always low in external mode.
- R8: Bits leave MSB first. `ser_out` takes the next bit on the clock edge where the selected data clock rises, and only while `host_sel_n`=0. Codes 0x7FFF (+full scale −1 LSB), 0x0000 (midscale), 0xFFFF (midscale −1 LSB) and 0x8000 (−full scale) are read back unchanged.
- R9: A synchronous active-high `rst` clears both registers to 0, drives `ser_out` and `dclk_out` low and clears `result_lost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_busy | input | 1 | High while a conversion is in progress |
| bit_strobe | input | 1 | One-cycle strobe for one bit decision |
| bit_idx | input | $clog2(WIDTH) | Bit position of the decision |
| bit_val | input | 1 | Comparator decision for that bit |
| ext_clk_sel | input | 1 | 1 = host data clock, 0 = internal burst |
| ext_dclk | input | 1 | Host data clock, sampled by `clk` |
| host_sel_n | input | 1 | Active-low host select, enables shifting |
| ser_out | output | 1 | Serial result, MSB first |
| dclk_out | output | 1 | Generated data clock in internal mode |
| result_lost | output | 1 | Sticky flag: a result was dropped |

## Verification
The bench builds the block with WIDTH=16 and HALF_DIV=3. The odd divider checks that the burst timing does not depend on a power-of-two count, and a 16-bit word gives direct access to the four named two's complement codes. With these values an internal burst lasts 96 cycles, which is short enough to run a full burst and confirm its exact pulse count. Runs in external mode use host clocks several cycles long, which lets the bench place the host clock's high level and the select precisely around the load edge, both to force suppression and to avoid it.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

    typedef enum logic {
        DCLK_SRC_INT = 1'b0,
        DCLK_SRC_EXT = 1'b1
    } dclk_src_e;

endpackage

// File: rtl/sar_work_reg.sv
module sar_work_reg #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned IDXW  = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_strobe,
    input  logic [IDXW-1:0]  bit_idx,
    input  logic             bit_val,
    output logic [WIDTH-1:0] word_o
);

    logic [WIDTH-1:0] word_d, word_q;

    // one enable per flop: each decision lands on its own bit
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_comb begin
            word_d[g] = word_q[g];
            if (bit_strobe && (bit_idx == IDXW'(g))) begin
                word_d[g] = bit_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    assign word_o = word_q;

    assert_strobe_bit_R1: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |=> (word_q[$past(bit_idx)] == $past(bit_val)));

endmodule

// File: rtl/sar_dclk_gen.sv
module sar_dclk_gen #(
    parameter int unsigned WIDTH    = 16,
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic dclk_o,
    output logic rise_o
);

    localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int unsigned LW = $clog2(WIDTH + 1);

    typedef struct packed {
        logic          active;
        logic          dclk;
        logic [DW-1:0] div;
        logic [LW-1:0] left;
    } gen_t;

    gen_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        rise_o = 1'b0;
        if (start) begin
            st_d.active = 1'b1;
            st_d.dclk   = 1'b0;
            st_d.div    = '0;
            st_d.left   = LW'(WIDTH);
        end else if (st_q.active) begin
            if (st_q.div == DW'(HALF_DIV - 1)) begin
                st_d.div  = '0;
                st_d.dclk = ~st_q.dclk;
                if (st_q.dclk) begin
                    st_d.left = st_q.left - 1'b1;
                    if (st_q.left == LW'(1)) begin
                        st_d.active = 1'b0;
                    end
                end else begin
                    rise_o = 1'b1;
                end
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dclk_o = st_q.dclk;

    assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
        !st_q.active |-> !st_q.dclk);

    assert_fall_counts_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(st_q.dclk) && !$past(start)) |->
            (st_q.left == LW'($past(st_q.left) - 1'b1)));

endmodule

// File: rtl/sar_out_shift.sv
module sar_out_shift #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             ext_sel,
    input  logic             ext_dclk,
    input  logic             sel_n,
    input  logic             int_rise,
    input  logic [WIDTH-1:0] word_i,
    output logic             load_o,
    output logic             sout_o,
    output logic             lost_o
);

    typedef struct packed {
        logic             busy;
        logic             ext;
        logic             sout;
        logic             lost;
        logic [WIDTH-1:0] sreg;
    } shf_t;

    shf_t st_d, st_q;
    logic end_ev, begin_ev, ext_rise, suppress, shift_ev;

    always_comb begin
        end_ev   = st_q.busy & ~busy;
        begin_ev = ~st_q.busy & busy;
        ext_rise = ext_dclk & ~st_q.ext;
        suppress = ext_sel & ext_dclk & ~sel_n;
        load_o   = end_ev & ~suppress;
        shift_ev = ~sel_n & (ext_sel ? ext_rise : int_rise);

        st_d      = st_q;
        st_d.busy = busy;
        st_d.ext  = ext_dclk;
        if (load_o) begin
            st_d.sreg = word_i;
        end else if (shift_ev) begin
            st_d.sout = st_q.sreg[WIDTH-1];
            st_d.sreg = {st_q.sreg[WIDTH-2:0], 1'b0};
        end
        if (begin_ev) begin
            st_d.lost = 1'b0;
        end else if (end_ev && suppress) begin
            st_d.lost = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sout_o = st_q.sout;
    assign lost_o = st_q.lost;

    assert_hold_in_conv_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && busy && !shift_ev) |=> $stable(st_q.sreg));

    assert_suppress_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (end_ev && ext_sel && ext_dclk && !sel_n) |=> (lost_o && $stable(st_q.sreg)));

    assert_lost_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !st_q.busy) |=> !lost_o);

    assert_quiet_unselected_R8: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> $stable(sout_o));

endmodule

// File: rtl/sar_result_port.sv
module sar_result_port
    import sar_port_pkg::*;
#(
    parameter int unsigned WIDTH    = 16,
    parameter int unsigned HALF_DIV = 2,
    localparam int unsigned IDXW    = $clog2(WIDTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            conv_busy,
    input  logic            bit_strobe,
    input  logic [IDXW-1:0] bit_idx,
    input  logic            bit_val,
    input  logic            ext_clk_sel,
    input  logic            ext_dclk,
    input  logic            host_sel_n,
    output logic            ser_out,
    output logic            dclk_out,
    output logic            result_lost
);

    dclk_src_e        src;
    logic [WIDTH-1:0] work_word;
    logic             load, int_dclk, int_rise, burst_start;

    assign src         = dclk_src_e'(ext_clk_sel);
    assign burst_start = load && (src == DCLK_SRC_INT);

    sar_work_reg #(.WIDTH(WIDTH), .IDXW(IDXW)) u_work (
        .clk        (clk),
        .rst        (rst),
        .bit_strobe (bit_strobe),
        .bit_idx    (bit_idx),
        .bit_val    (bit_val),
        .word_o     (work_word)
    );

    sar_dclk_gen #(.WIDTH(WIDTH), .HALF_DIV(HALF_DIV)) u_dclk (
        .clk    (clk),
        .rst    (rst),
        .start  (burst_start),
        .dclk_o (int_dclk),
        .rise_o (int_rise)
    );

    sar_out_shift #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .busy     (conv_busy),
        .ext_sel  (src == DCLK_SRC_EXT),
        .ext_dclk (ext_dclk),
        .sel_n    (host_sel_n),
        .int_rise (int_rise),
        .word_i   (work_word),
        .load_o   (load),
        .sout_o   (ser_out),
        .lost_o   (result_lost)
    );

    assign dclk_out = (src == DCLK_SRC_INT) ? int_dclk : 1'b0;

endmodule

// File: tb/sar_result_port_bench.sv
module sar_result_port_bench;

    localparam int W = 16;
    localparam int H = 3;
    localparam int IW = $clog2(W);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic conv_busy = 1'b0, bit_strobe = 1'b0, bit_val = 1'b0;
    logic [IW-1:0] bit_idx = '0;
    logic ext_clk_sel = 1'b1, ext_dclk = 1'b0, host_sel_n = 1'b1;
    logic ser_out, dclk_out, result_lost;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sar_result_port #(.WIDTH(W), .HALF_DIV(H)) u_sar_result_port (
        .clk(clk), .rst(rst), .conv_busy(conv_busy), .bit_strobe(bit_strobe),
        .bit_idx(bit_idx), .bit_val(bit_val), .ext_clk_sel(ext_clk_sel),
        .ext_dclk(ext_dclk), .host_sel_n(host_sel_n), .ser_out(ser_out),
        .dclk_out(dclk_out), .result_lost(result_lost)
    );

    // ---------------- behavioural reference ----------------
    logic [W-1:0] m_work;
    bit           m_q[$];
    logic         m_sout, m_lost, m_busy_prev, m_ext_prev, m_dclk;
    int           m_t;
    bit           m_run;

    always @(posedge clk) begin
        bit end_ev, supp, ld, irise;
        if (rst) begin
            m_work = '0; m_q.delete(); m_sout = 0; m_lost = 0;
            m_busy_prev = 0; m_ext_prev = 0; m_dclk = 0; m_t = 0; m_run = 0;
        end else begin
            end_ev = m_busy_prev && !conv_busy;
            supp   = ext_clk_sel && ext_dclk && !host_sel_n;
            ld     = end_ev && !supp;
            irise  = 0;
            if (ld && !ext_clk_sel) begin
                m_run = 1; m_t = 0;
            end else if (m_run) begin
                m_t++;
                if (m_t % (2*H) == H) irise = 1;
                if (m_t >= 2*H*W) m_run = 0;
            end
            m_dclk = m_run && ((m_t / H) % 2 == 1);
            if (ld) begin
                m_q.delete();
                for (int i = W-1; i >= 0; i--) m_q.push_back(m_work[i]);
            end else if (!host_sel_n && (ext_clk_sel ? (ext_dclk && !m_ext_prev) : irise)) begin
                m_sout = (m_q.size() > 0) ? m_q.pop_front() : 1'b0;
            end
            if (conv_busy && !m_busy_prev) m_lost = 0;
            else if (end_ev && supp) m_lost = 1;
            if (bit_strobe) m_work[bit_idx] = bit_val;
            m_busy_prev = conv_busy;
            m_ext_prev  = ext_dclk;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks += 3;
            if (ser_out !== m_sout) begin
                fails++; $display("FAIL R8 ser_out per-cycle: got %b exp %b", ser_out, m_sout);
            end
            if (dclk_out !== (ext_clk_sel ? 1'b0 : m_dclk)) begin
                fails++; $display("FAIL R7 dclk_out per-cycle: got %b exp %b", dclk_out, m_dclk && !ext_clk_sel);
            end
            if (result_lost !== m_lost) begin
                fails++; $display("FAIL R4 result_lost per-cycle: got %b exp %b", result_lost, m_lost);
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    task automatic start_conv();
        conv_busy = 1'b1; tick(1);
    endtask

    task automatic strobes(input logic [W-1:0] w, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            bit_strobe = 1'b1; bit_idx = IW'(i); bit_val = w[i]; tick(1);
        end
        bit_strobe = 1'b0;
    endtask

    task automatic end_conv();
        conv_busy = 1'b0; tick(2);
    endtask

    task automatic convert(input logic [W-1:0] w);
        start_conv(); strobes(w, W-1, 0); end_conv();
    endtask

    task automatic read_word(output logic [W-1:0] w);
        w = '0;
        host_sel_n = 1'b0;
        for (int i = 0; i < W; i++) begin
            ext_dclk = 1'b1; tick(2);
            ext_dclk = 1'b0; tick(1);
            w = {w[W-2:0], ser_out};
            tick(1);
        end
        host_sel_n = 1'b1; tick(1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [W-1:0] rd;
        logic [W-1:0] codes [4];
        int pulses;
        logic prev_d;

        tick(3);
        rst = 1'b0;
        tick(1);
        check("R9 ser_out after reset", W'(ser_out), '0);
        check("R9 dclk_out after reset", W'(dclk_out), '0);
        check("R9 result_lost after reset", W'(result_lost), '0);
        read_word(rd);
        check("R9 shift register cleared", rd, '0);

        // two's complement codes through external mode
        codes[0] = 16'h7FFF; codes[1] = 16'h0000; codes[2] = 16'hFFFF; codes[3] = 16'h8000;
        for (int k = 0; k < 4; k++) begin
            convert(codes[k]);
            read_word(rd);
            check("R2 R8 code readback", rd, codes[k]);
        end

        // R1: overwrite a single bit
        start_conv(); strobes(16'hFFFF, W-1, 0); strobes(16'h0000, 3, 3); end_conv();
        read_word(rd);
        check("R1 single-bit overwrite", rd, 16'hFFF7);

        // R3: read during conversion returns previous word
        convert(16'h1234);
        start_conv();
        strobes(16'hBEEF, W-1, 8);
        read_word(rd);
        check("R3 read during busy", rd, 16'h1234);
        strobes(16'hBEEF, 7, 0);
        end_conv();
        read_word(rd);
        check("R2 new word after end", rd, 16'hBEEF);

        // R4: suppressed load
        convert(16'h4321);
        start_conv(); strobes(16'h9C9C, W-1, 0);
        host_sel_n = 1'b1; ext_dclk = 1'b1; tick(1);
        host_sel_n = 1'b0; tick(1);
        end_conv();
        host_sel_n = 1'b1; tick(1);
        ext_dclk = 1'b0; tick(1);
        check("R4 lost set", W'(result_lost), 1);
        read_word(rd);
        check("R4 old word kept", rd, 16'h4321);
        check("R6 lost still set", W'(result_lost), 1);
        start_conv();
        check("R6 lost cleared at start", W'(result_lost), 0);
        strobes(16'h0F0F, W-1, 0);

        // R5: clock high but select high -> load
        ext_dclk = 1'b1; tick(1);
        end_conv();
        check("R5 no loss when deselected", W'(result_lost), 0);
        ext_dclk = 1'b0; tick(1);
        read_word(rd);
        check("R5 loaded with select high", rd, 16'h0F0F);

        // R5: select low but clock low -> load
        start_conv(); strobes(16'hC3A5, W-1, 0);
        host_sel_n = 1'b0; tick(1);
        end_conv();
        host_sel_n = 1'b1; tick(1);
        check("R5 no loss with clock low", W'(result_lost), 0);
        read_word(rd);
        check("R5 loaded with clock low", rd, 16'hC3A5);

        // R7/R8: internal burst
        ext_clk_sel = 1'b0;
        host_sel_n  = 1'b0;
        convert(16'h5A3C);
        pulses = 0; rd = '0; prev_d = 1'b0;
        for (int c = 0; c < 2*H*W + 20; c++) begin
            if (dclk_out && !prev_d) pulses++;
            if (!dclk_out && prev_d) rd = {rd[W-2:0], ser_out};
            prev_d = dclk_out;
            tick(1);
        end
        check("R7 pulse count", W'(pulses), W'(W));
        check("R8 internal readout", rd, 16'h5A3C);
        check("R7 idle low after burst", W'(dclk_out), 0);

        // R8: burst with select high does not move ser_out
        host_sel_n = 1'b1;
        convert(16'h0001);
        prev_d = ser_out;
        pulses = 0;
        for (int c = 0; c < 2*H*W + 10; c++) begin
            if (ser_out !== prev_d) pulses++;
            tick(1);
        end
        check("R8 no shift while deselected", W'(pulses), 0);

        tick(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule